// File: doc/BRIEF.md
# Telecom drop bus output formatter

This block turns an internal, already aligned SDH/SONET byte stream into a byte-wide telecom drop bus. Each clock it takes one byte together with flags that say where the byte sits in the frame: frame start (the J0 byte), J1, V1, payload, and the two pointer byte positions. It registers the byte onto the bus. At the two pointer positions it substitutes the pointer value supplied by upstream pointer logic. It drives a single marker lead for J0, J1 and, when enabled, V1. It also drives a payload indication, a parity bit and a bus clock.

Four configuration inputs set the bus behaviour: the parity sense, whether parity also covers the marker and payload leads, whether V1 marking is on, and which edge of the bus clock the outputs change on. All logic runs on the rising edge of the internal clock. Edge selection is done by driving the bus clock either true or inverted. Configuration is captured only on the frame-start byte, so one frame never mixes two parity rules. Transport overhead bytes other than the pointer bytes pass through unchanged and receivers treat them as don't-care.

Top module: `dbus_drop_fmt`

## Requirements
- R1: While reset is held, and right after it, bus_data is 0, bus_mark and bus_spe are 0, and bus_par is 1 (odd parity over all-zero bits). Configuration resets to odd parity, data-only scope, V1 marking off and non-inverted bus clock.
- R2: bus_data equals in_byte from the previous clock, with bit 7 carrying the first bit of the byte in line order, whenever neither pointer flag was set.
- R3: A byte flagged in_is_h1 is replaced on the bus by ptr_word[15:8], and a byte flagged in_is_h2 by ptr_word[7:0]. If both flags are set, the in_is_h1 substitution wins.
- R4: bus_mark is high for exactly the one clock carrying a byte flagged in_sof (J0) or in_j1, one clock after the flag.
- R5: A byte flagged in_v1 raises bus_mark only when V1 marking (cfg_v1_en) is active for that frame. Otherwise the marker stays low for that byte.
- R6: bus_spe equals in_spe from the previous clock.
- R7: With cfg_par_even = 0 the covered bits plus bus_par hold an odd number of ones. With cfg_par_even = 1 they hold an even number.
- R8: With cfg_par_timing = 0 parity covers bus_data only. With cfg_par_timing = 1 it covers bus_data, bus_mark and bus_spe of the same clock.
- R9: With cfg_neg_edge = 0 bus_clk equals clk. With cfg_neg_edge = 1 bus_clk is the inverse of clk, so the outputs change on its falling edge.
- R10: The configuration inputs are sampled only on a clock where in_sof is 1, and they apply from that frame-start byte onward. Changes at any other time have no effect until the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal byte clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Incoming frame byte, bit 7 first in line order |
| in_sof | input | 1 | Byte is the J0 byte (frame start) |
| in_j1 | input | 1 | Byte is the J1 byte |
| in_v1 | input | 1 | Byte is a V1 byte |
| in_spe | input | 1 | Byte is payload |
| in_is_h1 | input | 1 | Byte position of pointer byte H1 |
| in_is_h2 | input | 1 | Byte position of pointer byte H2 |
| ptr_word | input | 16 | Pointer value, H1 in upper byte, H2 in lower |
| cfg_par_even | input | 1 | 0 odd parity, 1 even parity |
| cfg_par_timing | input | 1 | 1 to include marker and payload leads in parity |
| cfg_v1_en | input | 1 | 1 to mark V1 bytes |
| cfg_neg_edge | input | 1 | 1 to invert bus clock |
| bus_clk | output | 1 | Bus clock |
| bus_data | output | 8 | Bus data byte |
| bus_par | output | 1 | Bus parity |
| bus_mark | output | 1 | Combined J0/J1/V1 marker |
| bus_spe | output | 1 | Payload indication |

## Verification
The bench runs every combination of the four configuration bits across successive frames. In each frame it changes the configuration inputs mid-frame, and a design that sampled them continuously would show wrong parity or a wrong clock phase before the next J0 byte. It sets both pointer flags on one byte: a design with the wrong priority puts the H2 value on the bus. It places V1 bytes in frames with marking both on and off, where a wrong gate shows a stray or missing marker pulse. Parity is checked with the timing leads high and low under both scopes, so a design that ignored the scope bit or inverted the sense fails on the marker and payload bytes.

// File: rtl/drop_bus_pkg.sv
package drop_bus_pkg;

    typedef struct packed {
        logic neg_edge;
        logic v1_en;
        logic par_timing;
        logic par_even;
    } bus_cfg_t;

    localparam bus_cfg_t CFG_RESET = '{neg_edge: 1'b0, v1_en: 1'b0,
                                       par_timing: 1'b0, par_even: 1'b0};

endpackage

// File: rtl/dbus_cfg_hold.sv
module dbus_cfg_hold
    import drop_bus_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sof,
    input  bus_cfg_t cfg_in,
    output bus_cfg_t cfg_act,
    output bus_cfg_t cfg_q
);

    typedef struct packed {
        logic     live;
        bus_cfg_t cfg;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        if (sof) begin
            st_d.cfg = cfg_in;
        end
        cfg_act = st_d.cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.live <= 1'b0;
            st_q.cfg  <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_q = st_q.cfg;

    // R10: configuration holds between frame starts
    a_r10_cfg_only_at_sof: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && !$past(sof)) |-> $stable(cfg_q));

    // R10: frame start loads the configuration inputs
    a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(sof)) |-> (cfg_q == $past(cfg_in)));

endmodule

// File: rtl/dbus_lane_fmt.sv
module dbus_lane_fmt
    import drop_bus_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PTR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_sof,
    input  logic              in_j1,
    input  logic              in_v1,
    input  logic              in_spe,
    input  logic              in_is_h1,
    input  logic              in_is_h2,
    input  logic [PTR_W-1:0]  ptr_word,
    input  bus_cfg_t          cfg_act,
    output logic [DATA_W-1:0] data_q,
    output logic              mark_q,
    output logic              spe_q
);

    typedef struct packed {
        logic              live;
        logic [DATA_W-1:0] data;
        logic              mark;
        logic              spe;
    } lane_t;

    lane_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.live = 1'b1;
        if (in_is_h1) begin
            st_d.data = ptr_word[PTR_W-1:DATA_W];
        end else if (in_is_h2) begin
            st_d.data = ptr_word[DATA_W-1:0];
        end else begin
            st_d.data = in_byte;
        end
        st_d.mark = in_sof | in_j1 | (in_v1 & cfg_act.v1_en);
        st_d.spe  = in_spe;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q = st_q.data;
    assign mark_q = st_q.mark;
    assign spe_q  = st_q.spe;

    // R2: plain bytes pass with one clock of latency
    a_r2_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && !$past(in_is_h1) && !$past(in_is_h2)) |-> (data_q == $past(in_byte)));

    // R3: H1 position carries the upper pointer byte
    a_r3_h1_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(in_is_h1)) |-> (data_q == $past(ptr_word[PTR_W-1:DATA_W])));

    // R3: H2 position carries the lower pointer byte
    a_r3_h2_insert: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && $past(in_is_h2) && !$past(in_is_h1)) |-> (data_q == $past(ptr_word[DATA_W-1:0])));

    // R4: J0 and J1 always mark
    a_r4_j0_j1_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && ($past(in_sof) || $past(in_j1))) |-> mark_q);

    // R4, R5: no mark without a flagged byte
    a_r5_no_stray_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && !$past(in_sof) && !$past(in_j1) && !$past(in_v1)) |-> !mark_q);

    // R6: payload indication delayed one clock
    a_r6_spe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> (spe_q == $past(in_spe)));

endmodule

// File: rtl/dbus_parity.sv
module dbus_parity #(
    parameter int WIDTH = 10
) (
    input  logic [WIDTH-1:0] bits,
    input  logic             even,
    output logic             par
);

    logic [WIDTH:0] chain;

    assign chain[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_xor
        assign chain[i+1] = chain[i] ^ bits[i];
    end

    assign par = chain[WIDTH] ^ ~even;

endmodule

// File: rtl/dbus_drop_fmt.sv
module dbus_drop_fmt
    import drop_bus_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int PTR_W = 2 * DATA_W,
    localparam int PAR_W = DATA_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_sof,
    input  logic              in_j1,
    input  logic              in_v1,
    input  logic              in_spe,
    input  logic              in_is_h1,
    input  logic              in_is_h2,
    input  logic [PTR_W-1:0]  ptr_word,
    input  logic              cfg_par_even,
    input  logic              cfg_par_timing,
    input  logic              cfg_v1_en,
    input  logic              cfg_neg_edge,
    output logic              bus_clk,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_par,
    output logic              bus_mark,
    output logic              bus_spe
);

    bus_cfg_t cfg_in, cfg_act, cfg_q;
    logic [PAR_W-1:0] par_bits;

    assign cfg_in = '{neg_edge: cfg_neg_edge, v1_en: cfg_v1_en,
                      par_timing: cfg_par_timing, par_even: cfg_par_even};

    dbus_cfg_hold i_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (in_sof),
        .cfg_in  (cfg_in),
        .cfg_act (cfg_act),
        .cfg_q   (cfg_q)
    );

    dbus_lane_fmt #(.DATA_W(DATA_W)) i_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_byte  (in_byte),
        .in_sof   (in_sof),
        .in_j1    (in_j1),
        .in_v1    (in_v1),
        .in_spe   (in_spe),
        .in_is_h1 (in_is_h1),
        .in_is_h2 (in_is_h2),
        .ptr_word (ptr_word),
        .cfg_act  (cfg_act),
        .data_q   (bus_data),
        .mark_q   (bus_mark),
        .spe_q    (bus_spe)
    );

    assign par_bits = {bus_data, bus_mark & cfg_q.par_timing, bus_spe & cfg_q.par_timing};

    dbus_parity #(.WIDTH(PAR_W)) i_par (
        .bits (par_bits),
        .even (cfg_q.par_even),
        .par  (bus_par)
    );

    assign bus_clk = clk ^ cfg_q.neg_edge;

    // R7, R8: total ones over covered leads matches selected sense
    a_r7_parity_sense: assert property (@(posedge clk) disable iff (!rst_n)
        ((^{bus_data, bus_par}) ^ (cfg_q.par_timing & (bus_mark ^ bus_spe))) == !cfg_q.par_even);

    // R8: in data-only scope the timing leads never move parity
    a_r8_scope_data_only: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q.par_timing |-> (bus_par == ((^bus_data) ^ !cfg_q.par_even)));

endmodule

// File: tb/test_dbus_drop_fmt.sv
`timescale 1ns/1ps
module test_dbus_drop_fmt;

    localparam int FL = 30;
    localparam int NF = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_sof = 0, in_j1 = 0, in_v1 = 0, in_spe = 0, in_is_h1 = 0, in_is_h2 = 0;
    logic [15:0] ptr_word = '0;
    logic        cfg_par_even = 0, cfg_par_timing = 0, cfg_v1_en = 0, cfg_neg_edge = 0;
    logic        bus_clk, bus_par, bus_mark, bus_spe;
    logic [7:0]  bus_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dbus_drop_fmt i_dbus_drop_fmt (
        .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_sof(in_sof), .in_j1(in_j1),
        .in_v1(in_v1), .in_spe(in_spe), .in_is_h1(in_is_h1), .in_is_h2(in_is_h2),
        .ptr_word(ptr_word), .cfg_par_even(cfg_par_even), .cfg_par_timing(cfg_par_timing),
        .cfg_v1_en(cfg_v1_en), .cfg_neg_edge(cfg_neg_edge), .bus_clk(bus_clk),
        .bus_data(bus_data), .bus_par(bus_par), .bus_mark(bus_mark), .bus_spe(bus_spe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // model state
    bit [3:0] m_cfg = 4'b0000;  // {neg, v1_en, timing, even}
    bit [7:0] e_data;
    bit e_mark, e_spe, e_par, e_clk;
    bit have_exp = 0;

    task automatic compare();
        check(bus_data == e_data, "R2/R3 data", bus_data, e_data);
        check(bus_mark == e_mark, "R4/R5 mark", bus_mark, e_mark);
        check(bus_spe == e_spe, "R6 spe", bus_spe, e_spe);
        check(bus_par == e_par, "R7/R8 parity", bus_par, e_par);
        check(bus_clk == e_clk, "R9/R10 bus clock", bus_clk, e_clk);
    endtask

    task automatic model_step();
        bit [3:0] act;
        int ones;
        act = in_sof ? {cfg_neg_edge, cfg_v1_en, cfg_par_timing, cfg_par_even} : m_cfg;
        if (in_sof) m_cfg = act;
        if (in_is_h1)      e_data = ptr_word[15:8];
        else if (in_is_h2) e_data = ptr_word[7:0];
        else               e_data = in_byte;
        e_mark = in_sof || in_j1 || (in_v1 && act[2]);
        e_spe  = in_spe;
        ones = 0;
        for (int b = 0; b < 8; b++) if (e_data[b]) ones++;
        if (act[1]) ones += int'(e_mark) + int'(e_spe);
        if (act[0]) e_par = (ones % 2) == 1;   // even sense
        else        e_par = (ones % 2) == 0;   // odd sense
        e_clk = act[3];                         // sampled while clk is low
        have_exp = 1;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check(bus_data == 8'h00, "R1 reset data", bus_data, 0);
        check(bus_mark == 1'b0, "R1 reset mark", bus_mark, 0);
        check(bus_spe == 1'b0, "R1 reset spe", bus_spe, 0);
        check(bus_par == 1'b1, "R1 reset parity", bus_par, 1);
        check(bus_clk == 1'b0, "R1 reset bus clock", bus_clk, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_par == 1'b1, "R1 parity after release", bus_par, 1);
        for (int f = 0; f < NF; f++) begin
            for (int p = 0; p < FL; p++) begin
                @(negedge clk);
                if (have_exp) compare();
                in_byte  = 8'($urandom);
                ptr_word = 16'($urandom);
                in_sof   = (p == 0);
                in_j1    = (p == 10);
                in_v1    = (p == 15) || (p == 22);
                in_spe   = (p >= 9) ? 1'($urandom) | (p == 10) : 1'b0;
                in_is_h1 = (p == 3) || (f == 5 && p == 4);   // R3 both flags in frame 5
                in_is_h2 = (p == 4);
                if (p == 0) begin
                    {cfg_neg_edge, cfg_v1_en, cfg_par_timing, cfg_par_even} = 4'(f);
                end else if (p == 12) begin
                    // R10: mid-frame change must not apply
                    {cfg_neg_edge, cfg_v1_en, cfg_par_timing, cfg_par_even} = ~4'(f);
                end
                model_step();
            end
        end
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule